// File: doc/BRIEF.md
# Accumulator Data-Move Execution Unit

This block carries out the data-transfer subset of a small 8-bit accumulator machine. It receives an already-decoded operation code with its operand fields: an immediate byte, two direct addresses and a working-register index. From these it performs accumulator loads, memory-to-memory copies, full and lower-nibble exchanges, and stack push and pop. The block holds all of the storage these transfers use: a 256-byte internal RAM, an accumulator and an 8-bit stack pointer. The eight working registers are the first eight bytes of that RAM, so a register access and a direct access to addresses 0x00 to 0x07 reach the same byte.

A caller raises `start` for one cycle with the fields valid. The unit latches the fields, resolves the effective address in a second cycle, and commits all updates in a third. It then pulses `done`, together with `illegal` when the operation was rejected. The accumulator and the stack pointer are visible on debug outputs, and any RAM byte can be read back by loading it into the accumulator.

Top module: `acc_move_unit`

## Requirements
- R1: Operation code 0 loads the immediate byte into the accumulator.
- R2: Code 1 loads the accumulator from direct address `dir_a`. Code 2 loads it from working register `reg_sel`.
- R3: Code 3 loads the accumulator from the RAM byte whose address is held in working register `reg_sel`.
- R4: Code 4 copies the byte at `dir_b` into `dir_a` and leaves the byte at `dir_b` unchanged.
- R5: Code 5 (push) adds one to SP and then writes the byte from `dir_a` to the new SP address.
- R6: Code 6 (pop) writes the byte at SP into `dir_a` and then subtracts one from SP.
- R7: Codes 7, 8 and 9 swap the accumulator in one operation with, respectively, working register `reg_sel`, direct address `dir_a`, or the byte addressed through working register `reg_sel`.
- R8: Code 10 swaps bits 3:0 of the accumulator with bits 3:0 of the byte addressed through working register `reg_sel`. Both upper nibbles stay unchanged.
- R9: Working register n is RAM address n (n = 0 to 7).
- R10: Codes 3, 9 and 10 accept only register index 0 or 1 as a pointer. Another index, or any code from 11 to 15, raises `illegal` together with `done` and changes no accumulator, SP or RAM state.
- R11: After reset the accumulator is 0x00, SP is 0x07, every RAM byte is 0x00, and `done` and `illegal` are low.
- R12: `done` is high for exactly one cycle, three clock edges after the edge that samples `start`. `start` has no effect while an operation is in progress.
- R13: SP wraps modulo 256 on both increment and decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 4 | Decoded operation code |
| imm | input | 8 | Immediate byte |
| dir_a | input | 8 | First direct address (destination or source) |
| dir_b | input | 8 | Second direct address (copy source) |
| reg_sel | input | 3 | Working-register index |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Operation rejected, pulses with done |
| acc_q | output | 8 | Accumulator value |
| sp_q | output | 8 | Stack pointer value |

## Verification
The hardest situation to reach is a pointer that aliases a working register, or a direct address that overlaps the stack. In those cases one transfer reads and writes the same byte through two different paths. The stimulus builds pointers with exchanges so that indirect accesses land on addresses 0x00 to 0x07 and near SP. It drives SP through its wrap point with long pop and push runs. A long run of random operations with full-range fields then mixes exchanges, copies and stack traffic on shared bytes. Each operation also re-raises `start` with a different request while the unit is busy, so that any leak of that request shows up in the accumulator.

// File: rtl/acc_move_unit.sv
module acc_move_unit #(
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter int NREG   = 8,
  parameter int NPTR   = 2,
  parameter int SP_RST = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [DW-1:0] imm,
  input  logic [AW-1:0] dir_a,
  input  logic [AW-1:0] dir_b,
  input  logic [$clog2(NREG)-1:0] reg_sel,
  output logic          done,
  output logic          illegal,
  output logic [DW-1:0] acc_q,
  output logic [AW-1:0] sp_q
);
  localparam int RW    = $clog2(NREG);
  localparam int DEPTH = 1 << AW;
  localparam int HN    = DW / 2;

  localparam logic [3:0] OP_LDI  = 4'd0;
  localparam logic [3:0] OP_LDD  = 4'd1;
  localparam logic [3:0] OP_LDR  = 4'd2;
  localparam logic [3:0] OP_LDN  = 4'd3;
  localparam logic [3:0] OP_MOV  = 4'd4;
  localparam logic [3:0] OP_PSH  = 4'd5;
  localparam logic [3:0] OP_POP  = 4'd6;
  localparam logic [3:0] OP_XR   = 4'd7;
  localparam logic [3:0] OP_XD   = 4'd8;
  localparam logic [3:0] OP_XN   = 4'd9;
  localparam logic [3:0] OP_XH   = 4'd10;
  localparam logic [3:0] OP_LAST = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_XFER} state_t;

  state_t        state;
  logic [3:0]    op_q;
  logic [DW-1:0] imm_q;
  logic [AW-1:0] a_q, b_q, ea_q;
  logic [RW-1:0] r_q;
  logic          bad_q;
  logic [DW-1:0] ram [DEPTH];

  logic [AW-1:0] reg_addr, ea_n, sp_inc, sp_dec;
  logic          is_ind, is_reg, bad_n;
  logic [DW-1:0] d_ea, d_a, d_b, d_sp;
  logic          we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  assign reg_addr = {{(AW-RW){1'b0}}, r_q};
  assign is_ind   = (op_q == OP_LDN) || (op_q == OP_XN) || (op_q == OP_XH);
  assign is_reg   = (op_q == OP_LDR) || (op_q == OP_XR);
  assign bad_n    = (op_q > OP_LAST) || (is_ind && (int'(r_q) >= NPTR));
  assign ea_n     = is_ind ? AW'(ram[reg_addr]) : (is_reg ? reg_addr : a_q);

  assign sp_inc = sp_q + AW'(1);
  assign sp_dec = sp_q - AW'(1);
  assign d_ea   = ram[ea_q];
  assign d_a    = ram[a_q];
  assign d_b    = ram[b_q];
  assign d_sp   = ram[sp_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      imm_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      r_q     <= '0;
      ea_q    <= '0;
      bad_q   <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q  <= op;
          imm_q <= imm;
          a_q   <= dir_a;
          b_q   <= dir_b;
          r_q   <= reg_sel;
          state <= S_ADDR;
        end
        S_ADDR: begin
          ea_q  <= ea_n;
          bad_q <= bad_n;
          state <= S_XFER;
        end
        default: begin
          done    <= 1'b1;
          illegal <= bad_q;
          state   <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      sp_q  <= AW'(SP_RST);
    end else if (state == S_XFER && !bad_q) begin
      case (op_q)
        OP_LDI:                     acc_q <= imm_q;
        OP_LDD, OP_LDR, OP_LDN:     acc_q <= d_ea;
        OP_XR, OP_XD, OP_XN:        acc_q <= d_ea;
        OP_XH:                      acc_q <= {acc_q[DW-1:HN], d_ea[HN-1:0]};
        OP_PSH:                     sp_q  <= sp_inc;
        OP_POP:                     sp_q  <= sp_dec;
        default: ;
      endcase
    end
  end

  always_comb begin
    we    = 1'b0;
    waddr = ea_q;
    wdata = acc_q;
    if (state == S_XFER && !bad_q) begin
      case (op_q)
        OP_MOV: begin we = 1'b1; waddr = a_q;    wdata = d_b;  end
        OP_PSH: begin we = 1'b1; waddr = sp_inc; wdata = d_a;  end
        OP_POP: begin we = 1'b1; waddr = a_q;    wdata = d_sp; end
        OP_XR, OP_XD, OP_XN: we = 1'b1;
        OP_XH: begin we = 1'b1; wdata = {d_ea[DW-1:HN], acc_q[HN-1:0]}; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else if (we) begin
      ram[waddr] <= wdata;
    end
  end

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |-> ##3 done);

  a_r12_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR) |=> (state == S_XFER));

  a_r10_illegal_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  a_r10_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($stable(acc_q) && $stable(sp_q)));

  a_r5_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER && op_q == OP_PSH && !bad_q) |=> sp_q == AW'($past(sp_q) + AW'(1)));

  a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER && op_q == OP_POP && !bad_q) |=> sp_q == AW'($past(sp_q) - AW'(1)));

  a_r8_upper_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER && op_q == OP_XH && !bad_q) |=> acc_q[DW-1:HN] == $past(acc_q[DW-1:HN]));

endmodule

// File: tb/test_acc_move_unit.sv
module test_acc_move_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] imm = '0, dir_a = '0, dir_b = '0;
  logic [2:0] reg_sel = '0;
  logic       done, illegal;
  logic [7:0] acc_q, sp_q;

  acc_move_unit i_acc_move_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .imm(imm),
    .dir_a(dir_a), .dir_b(dir_b), .reg_sel(reg_sel),
    .done(done), .illegal(illegal), .acc_q(acc_q), .sp_q(sp_q));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] mram [256];
  logic [7:0] m_acc, m_sp;
  logic       m_done, m_ill;
  logic       chk_en = 1'b0;
  string      cur_tag = "R11";

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en) begin
    check(done === m_done, "R12 done", done, m_done);
    check(illegal === m_ill, "R10 illegal", illegal, m_ill);
    check(acc_q === m_acc, {cur_tag, " acc"}, acc_q, m_acc);
    check(sp_q === m_sp, {cur_tag, " sp"}, sp_q, m_sp);
  end

  task automatic model(input logic [3:0] o, input logic [7:0] i, a, b, input logic [2:0] r,
                       output logic bad);
    logic [7:0] t, p;
    bad = 1'b0;
    p = mram[{5'd0, r}];
    case (o)
      4'd0: m_acc = i;
      4'd1: m_acc = mram[a];
      4'd2: m_acc = mram[{5'd0, r}];
      4'd3: if (r > 1) bad = 1'b1; else m_acc = mram[p];
      4'd4: mram[a] = mram[b];
      4'd5: begin t = mram[a]; m_sp = m_sp + 8'd1; mram[m_sp] = t; end
      4'd6: begin mram[a] = mram[m_sp]; m_sp = m_sp - 8'd1; end
      4'd7: begin t = mram[{5'd0, r}]; mram[{5'd0, r}] = m_acc; m_acc = t; end
      4'd8: begin t = mram[a]; mram[a] = m_acc; m_acc = t; end
      4'd9: if (r > 1) bad = 1'b1;
            else begin t = mram[p]; mram[p] = m_acc; m_acc = t; end
      4'd10: if (r > 1) bad = 1'b1;
             else begin
               t = mram[p];
               mram[p] = {t[7:4], m_acc[3:0]};
               m_acc = {m_acc[7:4], t[3:0]};
             end
      default: bad = 1'b1;
    endcase
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] i, a, b,
                     input logic [2:0] r, input string tag);
    logic bad;
    @(negedge clk);
    cur_tag = tag;
    op = o; imm = i; dir_a = a; dir_b = b; reg_sel = r; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op = 4'd0; imm = 8'hEE; dir_a = 8'h00; reg_sel = 3'd0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    model(o, i, a, b, r, bad);
    m_done = 1'b1;
    m_ill  = bad;
    @(posedge clk);
    m_done = 1'b0;
    m_ill  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mram[k] = 8'h00;
    m_acc = 8'h00; m_sp = 8'h07; m_done = 1'b0; m_ill = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1'b1;
    @(negedge clk);
    cur_tag = "R11";
    run(4'd1, 0, 8'hC3, 0, 0, "R11");
    run(4'd0, 8'h5A, 0, 0, 0, "R1");
    run(4'd8, 0, 8'h30, 0, 0, "R7");
    run(4'd1, 0, 8'h30, 0, 0, "R7");
    run(4'd0, 8'h40, 0, 0, 0, "R1");
    run(4'd7, 0, 0, 0, 3'd0, "R7");
    run(4'd1, 0, 8'h00, 0, 0, "R9");
    run(4'd0, 8'h9C, 0, 0, 0, "R1");
    run(4'd8, 0, 8'h40, 0, 0, "R7");
    run(4'd3, 0, 0, 0, 3'd0, "R3");
    run(4'd2, 0, 0, 0, 3'd0, "R2");
    run(4'd4, 0, 8'h50, 8'h30, 0, "R4");
    run(4'd1, 0, 8'h50, 0, 0, "R4");
    run(4'd1, 0, 8'h30, 0, 0, "R4");
    run(4'd5, 0, 8'h30, 0, 0, "R5");
    run(4'd2, 0, 0, 0, 3'd0, "R9");
    run(4'd1, 0, 8'h08, 0, 0, "R5");
    run(4'd6, 0, 8'h60, 0, 0, "R6");
    run(4'd1, 0, 8'h60, 0, 0, "R6");
    run(4'd3, 0, 0, 0, 3'd5, "R10");
    run(4'd9, 0, 0, 0, 3'd2, "R10");
    run(4'd15, 8'h11, 8'h20, 8'h21, 0, "R10");
    run(4'd0, 8'hA3, 0, 0, 0, "R1");
    run(4'd10, 0, 0, 0, 3'd0, "R8");
    run(4'd1, 0, 8'h40, 0, 0, "R8");
    run(4'd0, 8'h05, 0, 0, 0, "R1");
    run(4'd7, 0, 0, 0, 3'd1, "R9");
    run(4'd0, 8'h77, 0, 0, 0, "R1");
    run(4'd9, 0, 0, 0, 3'd1, "R7");
    run(4'd1, 0, 8'h05, 0, 0, "R7");
    for (int k = 0; k < 10; k++) run(4'd6, 0, 8'h70, 0, 0, "R13");
    for (int k = 0; k < 4; k++) run(4'd5, 0, 8'h05, 0, 0, "R13");
    for (int k = 0; k < 400; k++)
      run(4'($urandom_range(0, 12)), 8'($urandom), 8'($urandom),
          8'($urandom), 3'($urandom), "R7 mixed");
    for (int k = 0; k < 256; k++) run(4'd1, 0, 8'(k), 0, 0, "R4 dump");
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule